// File: doc/BRIEF.md
# Hiccup Overcurrent Guard

This block sits beside a buck controller's switching logic and decides when a sustained overload should halt switching. Once per switching cycle it gets a cycle strobe, together with a flag saying whether the valley current threshold was crossed in that cycle. A small saturating up/down event counter weighs these flags. An occasional over-limit cycle is forgotten again. An overload that keeps coming back pushes the counter to its top value, and then the block trips.

After a trip the block raises a driver-stop signal that holds both gate drivers off. It also forces the power-good indication low. It then waits a fixed number of switching cycles. At the end of that wait it releases the drivers and sends a one-clock restart request to the soft-start logic. Counting does not depend on soft-start, so the guard also protects during a ramp. Pulling the enable input low abandons any count or wait that is in progress.

Top module: `hiccup_guard`

## Requirements
- R1: After reset, drv_stop, restart_req and pgood_force are all 0.
- R2: The event count is 3 bits wide and starts at 0. A clock with cyc_tick=1 and vlim_hit=1 adds one to the count. When the count reaches 7, drv_stop is 1 from the clock edge that made it 7.
- R3: A clock with cyc_tick=1 and vlim_hit=0 takes one from the count. At 0 the count stays at 0 and does not wrap.
- R4: On a clock with cyc_tick=0 the count does not change, whatever vlim_hit is.
- R5: On the first clock after the count reaches 7, the timeout starts. drv_stop then stays 1 until the edge that carries the TIMEOUT_CYCLES-th cyc_tick of the timeout (default 4096), and goes to 0 at that edge.
- R6: restart_req is 1 for exactly one clock, right after the edge that ends the timeout. It is 0 at all other times.
- R7: The count is cleared when the timeout starts. vlim_hit is ignored while the timeout runs, so 7 fresh hits are needed to trip again after a restart.
- R8: pgood_force is 1 on every clock on which drv_stop is 1, including the whole timeout.
- R9: A clock edge with enable=0 clears both the count and the timeout. drv_stop goes to 0 with no restart pulse, and the next trip needs 7 fresh hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; 0 clears count and timeout |
| cyc_tick | input | 1 | One-clock strobe per switching cycle |
| vlim_hit | input | 1 | Valley current limit was reached in this switching cycle |
| drv_stop | output | 1 | Holds both gate drivers off |
| restart_req | output | 1 | One-clock request for a new soft-start |
| pgood_force | output | 1 | Forces power-good low |

## Verification
The bench feeds mixed hit/miss patterns that stay just short of a trip. A counter that saturated wrongly, or never went down, would trip on them. A run of misses from zero comes before a burst of hits; a counter that wrapped below zero would read 7 and trip at once. The length of the timeout is measured edge by edge, so a timer that is off by one, or that counts its entry clock, shows up. After a restart and after a disable, the bench checks that exactly 7 new hits are needed. A counter not cleared on entry would re-trip immediately, and a disable that did not clear would leave the drivers stopped or send a spurious restart.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic {
    HG_RUN  = 1'b0,
    HG_HOLD = 1'b1
  } hg_state_e;
endpackage

// File: rtl/hiccup_evt_counter.sv
// Saturating up/down event counter: counts up on hits, down on misses, floors at 0.
module hiccup_evt_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         up,
  output logic         full
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  assign full = (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (up) begin
        if (!full) cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hiccup_timeout.sv
// Counts switching-cycle ticks during the hold window and flags the last one.
module hiccup_timeout #(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic done
);
  localparam int TW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

  logic [TW-1:0] tmo_q;

  assign done = step && (tmo_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q <= '0;
    end else if (clr || done) begin
      tmo_q <= '0;
    end else if (step) begin
      tmo_q <= tmo_q + 1'b1;
    end
  end
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hiccup_pkg::*;
#(
  parameter int CNT_W          = 3,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cyc_tick,
  input  logic vlim_hit,
  output logic drv_stop,
  output logic restart_req,
  output logic pgood_force
);
  hg_state_e state_q;
  logic      cnt_full;
  logic      tmo_done;
  logic      trip;
  logic      holding;
  logic      restart_q;

  assign holding = (state_q == HG_HOLD);
  assign trip    = enable && !holding && cnt_full;

  hiccup_evt_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!enable || trip),
    .step  (cyc_tick && !holding),
    .up    (vlim_hit),
    .full  (cnt_full)
  );

  hiccup_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!enable || !holding),
    .step  (cyc_tick && holding),
    .done  (tmo_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HG_RUN;
      restart_q <= 1'b0;
    end else if (!enable) begin
      state_q   <= HG_RUN;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      case (state_q)
        HG_RUN:  if (trip) state_q <= HG_HOLD;
        HG_HOLD: if (tmo_done) begin
          state_q   <= HG_RUN;
          restart_q <= 1'b1;
        end
        default: state_q <= HG_RUN;
      endcase
    end
  end

  assign drv_stop    = holding || cnt_full;
  assign pgood_force = holding || cnt_full;
  assign restart_req = restart_q;
endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cyc_tick,
  input logic vlim_hit,
  input logic drv_stop,
  input logic restart_req,
  input logic pgood_force
);
  a_r6_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

  a_r6_restart_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_req) |-> ($past(drv_stop) && !drv_stop));

  a_r2_trip_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_stop) |-> $past(cyc_tick && vlim_hit && enable));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drv_stop && !restart_req));

  a_r8_pgood_follows: assert property (@(posedge clk) disable iff (!rst_n)
    drv_stop |-> pgood_force);
endmodule

bind hiccup_guard hiccup_guard_chk u_chk (.*);

// File: tb/tb_hiccup_guard.sv
module tb_hiccup_guard;
  localparam int TMO = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cyc_tick = 1'b0;
  logic vlim_hit = 1'b0;
  logic drv_stop, restart_req, pgood_force;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  hiccup_guard dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_tick(cyc_tick),
    .vlim_hit(vlim_hit), .drv_stop(drv_stop), .restart_req(restart_req),
    .pgood_force(pgood_force)
  );

  // {hit pattern bit i = hit on step i, first step index with drv_stop=1 (16 = none)}
  localparam logic [23:0] VEC [5] = '{
    {16'hFFFF, 8'd6},
    {16'h5555, 8'd16},
    {16'hB6DB, 8'd16},
    {16'hFFF8, 8'd9},
    {16'hFFBF, 8'd8}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Called at a negedge; drives inputs, returns at the next negedge.
  task automatic step(input logic t, input logic h);
    cyc_tick = t;
    vlim_hit = h;
    @(negedge clk);
  endtask

  task automatic clear_en();
    enable = 1'b0;
    step(1'b0, 1'b0);
    enable = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int n;
    @(negedge clk);
    @(negedge clk);
    check("R1 drv_stop", drv_stop, 0);
    check("R1 restart_req", restart_req, 0);
    check("R1 pgood_force", pgood_force, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);

    // R2 R3: vector table of hit/miss patterns
    foreach (VEC[v]) begin
      int trip_at;
      int seen;
      trip_at = int'(VEC[v][7:0]);
      seen = 16;
      for (int i = 0; i < 16; i++) begin
        step(1'b1, VEC[v][8+i]);
        if (drv_stop && seen == 16) seen = i;
        if (seen != 16) break;
      end
      check($sformatf("R2 R3 vector %0d trip step", v), seen, trip_at);
      check("R8 pgood with stop", pgood_force, drv_stop);
      clear_en();
    end

    // R4: no tick means no count
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    check("R4 no tick no trip", drv_stop, 0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    check("R4 six hits no trip", drv_stop, 0);
    step(1'b1, 1'b1);
    check("R2 seventh hit trips", drv_stop, 1);
    check("R8 pgood at trip", pgood_force, 1);

    // R5 R6 R8: timeout length, hits held high during it (R7)
    n = 0;
    while (drv_stop && n < TMO + 10) begin
      step(1'b1, 1'b1);
      n++;
      if (drv_stop && !pgood_force) check("R8 pgood during hold", 0, 1);
      if (drv_stop && restart_req) check("R6 early restart", 1, 0);
    end
    check("R5 hold length in edges", n, TMO + 1);
    check("R6 restart pulse", restart_req, 1);
    step(1'b1, 1'b0);
    check("R6 restart one cycle", restart_req, 0);
    check("R8 pgood released", pgood_force, 0);

    // R7: fresh count needed after restart
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    check("R7 six hits after restart", drv_stop, 0);
    step(1'b1, 1'b1);
    check("R7 seventh hit trips", drv_stop, 1);

    // R9: disable during the hold
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1);
    check("R9 holding before disable", drv_stop, 1);
    enable = 1'b0;
    step(1'b1, 1'b1);
    check("R9 stop cleared", drv_stop, 0);
    check("R9 no restart", restart_req, 0);
    enable = 1'b1;
    n = 0;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1);
      if (restart_req) n++;
    end
    check("R9 count cleared", drv_stop, 0);
    check("R9 no restart later", n, 0);
    step(1'b1, 1'b1);
    check("R9 seventh hit trips", drv_stop, 1);

    summary();
  end
endmodule